// File: doc/BRIEF.md
# SGMII PCS Configuration Register Bank

This block is the slave register bank that sits in front of an SGMII physical coding sublayer. Software reaches it over a simple word-addressed CSR bus. Each 16-bit register occupies the low half of a 32-bit word slot, so register index n sits at byte address 4·n. The bank holds the following registers:

- a scratch register for bus sanity tests;
- a fixed revision code;
- a link timer split into a low and a high part;
- an interface-mode register;
- two read-timeout storage registers;
- a PHY-style control register and two identifier registers.

The link timer value, the two interface-mode enables and the control fields are driven straight out to the coding and negotiation logic. Setting the reset bit of the control register starts an internal soft reset that lasts a fixed number of cycles. During that reset every register except scratch is held at its default. The reset bit reads back as 1 while the reset runs and clears itself at the end.

Top module: `pcs_cfg_bank`

## Requirements
- R1: A read strobe on `csr_rd` with byte address `csr_addr` selects register index `csr_addr >> 2`. On the next cycle `csr_rvalid` is high for one cycle and `csr_rdata` holds the register value in bits 15:0, with bits 31:16 always zero.
- R2: The scratch register (index 0x10) returns exactly the last value written, for any 16-bit pattern. A soft reset does not change it, and it can still be written while a soft reset runs.
- R3: The revision register (index 0x11) reads the parameter `REV` (default 0x0100). Writes to it have no effect.
- R4: The link timer low register (index 0x12, 16 bits) and high register (index 0x13, low 5 bits stored, upper bits read 0) form `link_timer = {high[4:0], low}`. Both default to 0.
- R5: In the interface-mode register (index 0x14), bit 0 drives `sgmii_mode_en` and bit 1 drives `sgmii_an_en`. Its other bits read 0, and it defaults to 0.
- R6: The control register (index 0) uses bit 15 as reset, bit 12 as autonegotiation enable (`an_enable`), bit 8 as full duplex (`full_duplex`) and bit 6 as speed-1000 (`speed_1000`). Its other bits read 0, and it defaults to 0x1000.
- R7: Writing the control register with bit 15 set starts a soft reset. `pcs_reset_busy` then stays high for exactly `RST_CYCLES` cycles (default 16). Control bit 15 reads 1 during that time. All registers except scratch return to their defaults, and writes to them are ignored; the written control bits are not kept.
- R8: The identifier registers (indices 2 and 3) read the parameters `ID_HI` and `ID_LO` (default 0x0000). Writes to them have no effect.
- R9: Reads of any index not listed in R2 to R10 return 0. Writes to such an index change no register.
- R10: Index 0x15 stores 1 bit (bit 0) and index 0x16 stores 16 bits. Both default to 0 and are cleared by a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| csr_wr | input | 1 | Write strobe |
| csr_rd | input | 1 | Read strobe |
| csr_wdata | input | 32 | Write data; bits 15:0 are used |
| csr_rdata | output | 32 | Registered read data |
| csr_rvalid | output | 1 | Read data valid, one cycle after `csr_rd` |
| link_timer | output | 16+HI_W | Combined link timer value |
| sgmii_mode_en | output | 1 | SGMII mode enable |
| sgmii_an_en | output | 1 | SGMII autonegotiation enable |
| an_enable | output | 1 | Control: autonegotiation enable |
| full_duplex | output | 1 | Control: full duplex |
| speed_1000 | output | 1 | Control: 1000 Mb/s select |
| pcs_reset_busy | output | 1 | Soft reset in progress |

## Verification
The scratch register is first driven with all-zeros, all-ones and the two alternating checkerboards. These patterns expose stuck, shorted or swapped data bits that a single value would hide. A long run of random writes and reads over the whole index range is then compared against a bench model. This run separates correct address decoding from aliasing, because a write landing on a wrong slot, or on an unmapped or read-only slot, shows up on a later read of a different index.

Directed soft-reset runs do three things:
- they time the busy window to the exact cycle;
- they read the control register mid-reset;
- they write scratch and link timer during the reset. This shows that only scratch keeps both its earlier content and the write made during the reset.

// File: rtl/pcs_cfg_pkg.sv
package pcs_cfg_pkg;
  localparam int IDX_CTRL    = 'h00;
  localparam int IDX_ID_HI   = 'h02;
  localparam int IDX_ID_LO   = 'h03;
  localparam int IDX_SCRATCH = 'h10;
  localparam int IDX_REV     = 'h11;
  localparam int IDX_TMR_LO  = 'h12;
  localparam int IDX_TMR_HI  = 'h13;
  localparam int IDX_MODE    = 'h14;
  localparam int IDX_NOTMO   = 'h15;
  localparam int IDX_RDTMO   = 'h16;

  localparam int CTRL_RST_BIT = 15;
  localparam int CTRL_AN_BIT  = 12;
  localparam int CTRL_FD_BIT  = 8;
  localparam int CTRL_SPD_BIT = 6;

  // control field defaults: {an, fd, spd}
  localparam logic [2:0] CTRL_FIELDS_DEFAULT = 3'b100;

  function automatic logic is_mapped(input int idx);
    case (idx)
      IDX_CTRL, IDX_ID_HI, IDX_ID_LO, IDX_SCRATCH, IDX_REV,
      IDX_TMR_LO, IDX_TMR_HI, IDX_MODE, IDX_NOTMO, IDX_RDTMO: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pcs_rst_seq.sv
module pcs_rst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/pcs_rw_reg.sv
module pcs_rw_reg #(
  parameter int         W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_n;

  always_comb begin
    q_n = q_r;
    if (clr)     q_n = RST_VAL;
    else if (we) q_n = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RST_VAL;
    else        q_r <= q_n;
  end

  assign q = q_r;
endmodule

// File: rtl/pcs_rd_mux.sv
module pcs_rd_mux
  import pcs_cfg_pkg::*;
#(
  parameter int          IDX_W = 6,
  parameter int          HI_W  = 5,
  parameter logic [15:0] REV   = 16'h0100,
  parameter logic [15:0] ID_HI = 16'h0000,
  parameter logic [15:0] ID_LO = 16'h0000
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             busy,
  input  logic [2:0]       ctrl_fields,
  input  logic [15:0]      scratch,
  input  logic [15:0]      tmr_lo,
  input  logic [HI_W-1:0]  tmr_hi,
  input  logic [1:0]       mode,
  input  logic             notmo,
  input  logic [15:0]      rdtmo,
  output logic [15:0]      value
);
  always_comb begin
    value = '0;
    case (int'(idx))
      IDX_CTRL: begin
        value[CTRL_RST_BIT] = busy;
        value[CTRL_AN_BIT]  = ctrl_fields[2];
        value[CTRL_FD_BIT]  = ctrl_fields[1];
        value[CTRL_SPD_BIT] = ctrl_fields[0];
      end
      IDX_ID_HI:   value = ID_HI;
      IDX_ID_LO:   value = ID_LO;
      IDX_SCRATCH: value = scratch;
      IDX_REV:     value = REV;
      IDX_TMR_LO:  value = tmr_lo;
      IDX_TMR_HI:  value[HI_W-1:0] = tmr_hi;
      IDX_MODE:    value[1:0] = mode;
      IDX_NOTMO:   value[0] = notmo;
      IDX_RDTMO:   value = rdtmo;
      default:     value = '0;
    endcase
  end
endmodule

// File: rtl/pcs_cfg_bank.sv
module pcs_cfg_bank
  import pcs_cfg_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          HI_W        = 5,
  parameter int          RST_CYCLES  = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] REV         = 16'h0100,
  parameter logic [15:0] ID_HI       = 16'h0000,
  parameter logic [15:0] ID_LO       = 16'h0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    csr_addr,
  input  logic                 csr_wr,
  input  logic                 csr_rd,
  input  logic [31:0]          csr_wdata,
  output logic [31:0]          csr_rdata,
  output logic                 csr_rvalid,
  output logic [16+HI_W-1:0]   link_timer,
  output logic                 sgmii_mode_en,
  output logic                 sgmii_an_en,
  output logic                 an_enable,
  output logic                 full_duplex,
  output logic                 speed_1000,
  output logic                 pcs_reset_busy
);
  localparam int IDX_W = ADDR_W - 2;

  // reset: asserted asynchronously, released through a synchronizer chain
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   arst_n;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign arst_n = sync_q[SYNC_STAGES-1];

  logic [IDX_W-1:0] idx;
  logic [15:0]      wd;
  logic             unused_bits;
  assign idx         = csr_addr[ADDR_W-1:2];
  assign wd          = csr_wdata[15:0];
  assign unused_bits = ^{csr_addr[1:0], csr_wdata[31:16]};

  logic busy, start, clr;
  logic hit_ctrl, hit_scr, hit_lo, hit_hi, hit_mode, hit_notmo, hit_rdtmo;

  always_comb begin
    hit_ctrl  = csr_wr && (int'(idx) == IDX_CTRL);
    hit_scr   = csr_wr && (int'(idx) == IDX_SCRATCH);
    hit_lo    = csr_wr && (int'(idx) == IDX_TMR_LO)  && !busy;
    hit_hi    = csr_wr && (int'(idx) == IDX_TMR_HI)  && !busy;
    hit_mode  = csr_wr && (int'(idx) == IDX_MODE)    && !busy;
    hit_notmo = csr_wr && (int'(idx) == IDX_NOTMO)   && !busy;
    hit_rdtmo = csr_wr && (int'(idx) == IDX_RDTMO)   && !busy;
    start     = hit_ctrl && !busy && wd[CTRL_RST_BIT];
    clr       = start || busy;
  end

  pcs_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst_n(arst_n), .start(start), .busy(busy)
  );

  logic [2:0]      ctrl_q;
  logic [15:0]     scr_q, lo_q, rdtmo_q;
  logic [HI_W-1:0] hi_q;
  logic [1:0]      mode_q;
  logic            notmo_q;

  pcs_rw_reg #(.W(3), .RST_VAL(CTRL_FIELDS_DEFAULT)) u_ctrl (
    .clk(clk), .rst_n(arst_n), .clr(clr),
    .we(hit_ctrl && !busy && !wd[CTRL_RST_BIT]),
    .d({wd[CTRL_AN_BIT], wd[CTRL_FD_BIT], wd[CTRL_SPD_BIT]}), .q(ctrl_q)
  );

  pcs_rw_reg #(.W(16), .RST_VAL(16'h0000)) u_scr (
    .clk(clk), .rst_n(arst_n), .clr(1'b0), .we(hit_scr), .d(wd), .q(scr_q)
  );

  pcs_rw_reg #(.W(16), .RST_VAL(16'h0000)) u_lo (
    .clk(clk), .rst_n(arst_n), .clr(clr), .we(hit_lo), .d(wd), .q(lo_q)
  );

  pcs_rw_reg #(.W(HI_W), .RST_VAL('0)) u_hi (
    .clk(clk), .rst_n(arst_n), .clr(clr), .we(hit_hi), .d(wd[HI_W-1:0]), .q(hi_q)
  );

  pcs_rw_reg #(.W(2), .RST_VAL(2'b00)) u_mode (
    .clk(clk), .rst_n(arst_n), .clr(clr), .we(hit_mode), .d(wd[1:0]), .q(mode_q)
  );

  pcs_rw_reg #(.W(1), .RST_VAL(1'b0)) u_notmo (
    .clk(clk), .rst_n(arst_n), .clr(clr), .we(hit_notmo), .d(wd[0]), .q(notmo_q)
  );

  pcs_rw_reg #(.W(16), .RST_VAL(16'h0000)) u_rdtmo (
    .clk(clk), .rst_n(arst_n), .clr(clr), .we(hit_rdtmo), .d(wd), .q(rdtmo_q)
  );

  logic [15:0] rd_val;
  pcs_rd_mux #(
    .IDX_W(IDX_W), .HI_W(HI_W), .REV(REV), .ID_HI(ID_HI), .ID_LO(ID_LO)
  ) u_mux (
    .idx(idx), .busy(busy), .ctrl_fields(ctrl_q), .scratch(scr_q),
    .tmr_lo(lo_q), .tmr_hi(hi_q), .mode(mode_q), .notmo(notmo_q),
    .rdtmo(rdtmo_q), .value(rd_val)
  );

  // read return path
  logic [15:0] rdata_q, rdata_d;
  logic        rvalid_q;

  always_comb begin
    rdata_d = rdata_q;
    if (csr_rd) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= csr_rd;
    end
  end

  assign csr_rdata      = {16'h0000, rdata_q};
  assign csr_rvalid     = rvalid_q;
  assign link_timer     = {hi_q, lo_q};
  assign sgmii_mode_en  = mode_q[0];
  assign sgmii_an_en    = mode_q[1];
  assign an_enable      = ctrl_q[2];
  assign full_duplex    = ctrl_q[1];
  assign speed_1000     = ctrl_q[0];
  assign pcs_reset_busy = busy;
endmodule

// File: rtl/pcs_cfg_bank_chk.sv
module pcs_cfg_bank_chk
  import pcs_cfg_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          HI_W   = 5,
  parameter logic [15:0] REV    = 16'h0100,
  parameter logic [15:0] ID_HI  = 16'h0000
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  csr_addr,
  input logic               csr_wr,
  input logic               csr_rd,
  input logic [31:0]        csr_wdata,
  input logic [31:0]        csr_rdata,
  input logic               csr_rvalid,
  input logic [16+HI_W-1:0] link_timer,
  input logic               sgmii_mode_en,
  input logic               sgmii_an_en,
  input logic               an_enable,
  input logic               full_duplex,
  input logic               speed_1000,
  input logic               pcs_reset_busy
);
  int rd_idx;
  assign rd_idx = int'(csr_addr[ADDR_W-1:2]);

  assert_rvalid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |=> csr_rvalid);

  assert_rvalid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |=> !csr_rvalid);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rvalid |-> csr_rdata[31:16] == 16'h0000);

  assert_rev_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && rd_idx == IDX_REV) |=> csr_rdata == {16'h0000, REV});

  assert_id_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && rd_idx == IDX_ID_HI) |=> csr_rdata == {16'h0000, ID_HI});

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && !is_mapped(rd_idx)) |=> csr_rdata == 32'h0);

  assert_busy_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_reset_busy |-> (link_timer == '0 && !sgmii_mode_en && !sgmii_an_en &&
                        an_enable && !full_duplex && !speed_1000));

  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcs_reset_busy) |-> $past(csr_wr && rd_idx == IDX_CTRL && csr_wdata[CTRL_RST_BIT]));
endmodule

bind pcs_cfg_bank pcs_cfg_bank_chk #(
  .ADDR_W(ADDR_W), .HI_W(HI_W), .REV(REV), .ID_HI(ID_HI)
) u_chk (.*);

// File: tb/pcs_cfg_bank_test.sv
module pcs_cfg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int HI_W       = 5;
  localparam int RST_CYCLES = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [ADDR_W-1:0]  csr_addr;
  logic               csr_wr, csr_rd;
  logic [31:0]        csr_wdata, csr_rdata;
  logic               csr_rvalid;
  logic [20:0]        link_timer;
  logic               sgmii_mode_en, sgmii_an_en, an_enable, full_duplex, speed_1000;
  logic               pcs_reset_busy;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] mdl [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcs_cfg_bank #(.ADDR_W(ADDR_W), .HI_W(HI_W), .RST_CYCLES(RST_CYCLES)) uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_rd(csr_rd), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_rvalid(csr_rvalid), .link_timer(link_timer),
    .sgmii_mode_en(sgmii_mode_en), .sgmii_an_en(sgmii_an_en),
    .an_enable(an_enable), .full_duplex(full_duplex),
    .speed_1000(speed_1000), .pcs_reset_busy(pcs_reset_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk);
    csr_addr  = ADDR_W'(idx * 4);
    csr_wdata = {16'hDEAD, d};
    csr_wr    = 1'b1;
    @(negedge clk);
    csr_wr    = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    csr_addr = ADDR_W'(idx * 4) | ADDR_W'(idx & 3);
    csr_rd   = 1'b1;
    @(negedge clk);
    csr_rd   = 1'b0;
    d        = csr_rvalid ? csr_rdata : 32'hBAD0BAD0;
  endtask

  // writable mask per index, from the requirements
  function automatic logic [15:0] wmask(input int idx);
    case (idx)
      'h00: return 16'h1140;
      'h10, 'h12, 'h16: return 16'hFFFF;
      'h13: return 16'h001F;
      'h14: return 16'h0003;
      'h15: return 16'h0001;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(input int idx);
    case (idx)
      'h11: return 16'h0100;
      'h02, 'h03: return 16'h0000;
      default: return mdl[idx];
    endcase
  endfunction

  function automatic string req_of(input int idx);
    case (idx)
      'h00: return "R6";
      'h02, 'h03: return "R8";
      'h10: return "R2";
      'h11: return "R3";
      'h12, 'h13: return "R4";
      'h14: return "R5";
      'h15, 'h16: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic model_soft_reset();
    for (int i = 0; i < 64; i++) if (i != 'h10) mdl[i] = 16'h0000;
    mdl[0] = 16'h1000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; csr_addr = '0; csr_wr = 1'b0; csr_rd = 1'b0; csr_wdata = '0;
    for (int i = 0; i < 64; i++) mdl[i] = 16'h0000;
    mdl[0] = 16'h1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd('h00, r); check("R6 ctrl default", r, 32'h1000);
    rd('h11, r); check("R3 revision", r, 32'h0100);
    rd('h02, r); check("R8 id hi", r, 32'h0);
    rd('h03, r); check("R8 id lo", r, 32'h0);
    check("R4 timer default", 32'(link_timer), 32'h0);
    check("R6 outputs default", {29'h0, an_enable, full_duplex, speed_1000}, 32'h4);
    check("R7 busy idle", 32'(pcs_reset_busy), 32'h0);

    // scratch patterns
    wr('h10, 16'h0000); rd('h10, r); check("R2 scratch 0000", r, 32'h0000);
    wr('h10, 16'hFFFF); rd('h10, r); check("R2 scratch FFFF", r, 32'hFFFF);
    wr('h10, 16'hA5A5); rd('h10, r); check("R2 scratch A5A5", r, 32'hA5A5);
    wr('h10, 16'h5A5A); rd('h10, r); check("R2 scratch 5A5A", r, 32'h5A5A);
    mdl['h10] = 16'h5A5A;

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int idx;
      logic [15:0] d;
      idx = int'($urandom_range(0, 63));
      d   = 16'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        if (idx == 0) d[15] = 1'b0;
        wr(idx, d);
        mdl[idx] = (mdl[idx] & ~wmask(idx)) | (d & wmask(idx));
      end else begin
        rd(idx, r);
        check(req_of(idx), r, {16'h0, exp_rd(idx)});
      end
    end
    for (int i = 0; i < 64; i++) begin
      rd(i, r); check(req_of(i), r, {16'h0, exp_rd(i)});
    end
    check("R4 link_timer random", 32'(link_timer), {11'h0, mdl['h13][4:0], mdl['h12]});
    check("R5 mode random", {30'h0, sgmii_an_en, sgmii_mode_en}, 32'(mdl['h14][1:0]));

    // directed timer / mode / ctrl
    wr('h12, 16'h0D40); wr('h13, 16'h0003);
    check("R4 link_timer 1.6ms", 32'(link_timer), 32'h30D40);
    wr('h13, 16'hFFFF); rd('h13, r); check("R4 high width", r, 32'h001F);
    wr('h14, 16'hFFFF); rd('h14, r); check("R5 mode readback", r, 32'h0003);
    check("R5 mode outputs", {30'h0, sgmii_an_en, sgmii_mode_en}, 32'h3);
    wr('h14, 16'h0001);
    check("R5 mode bit0 only", {30'h0, sgmii_an_en, sgmii_mode_en}, 32'h1);
    wr('h00, 16'h0140); rd('h00, r); check("R6 ctrl write", r, 32'h0140);
    check("R6 ctrl outputs", {29'h0, an_enable, full_duplex, speed_1000}, 32'h3);
    wr('h11, 16'h1234); rd('h11, r); check("R3 revision ignores write", r, 32'h0100);
    wr('h02, 16'hFFFF); rd('h02, r); check("R8 id ignores write", r, 32'h0);
    wr('h05, 16'hBEEF); rd('h05, r); check("R9 unmapped read", r, 32'h0);
    rd('h12, r); check("R9 unmapped write no alias", r, 32'h0D40);
    wr('h15, 16'hFFFF); rd('h15, r); check("R10 notmo width", r, 32'h1);
    wr('h16, 16'hC3C3); rd('h16, r); check("R10 rdtmo", r, 32'hC3C3);
    wr('h10, 16'hA5A5);

    // soft reset duration
    wr('h00, 16'h9140);
    check("R7 busy starts", 32'(pcs_reset_busy), 32'h1);
    repeat (RST_CYCLES - 1) @(negedge clk);
    check("R7 busy last cycle", 32'(pcs_reset_busy), 32'h1);
    @(negedge clk);
    check("R7 busy ends", 32'(pcs_reset_busy), 32'h0);
    rd('h00, r); check("R7 ctrl defaults after reset", r, 32'h1000);
    rd('h10, r); check("R2 scratch kept over reset", r, 32'hA5A5);
    rd('h16, r); check("R10 rdtmo cleared", r, 32'h0);
    rd('h15, r); check("R10 notmo cleared", r, 32'h0);
    check("R7 timer cleared", 32'(link_timer), 32'h0);

    // soft reset contents
    wr('h12, 16'h1111); wr('h14, 16'h0003);
    wr('h00, 16'h8000);
    rd('h00, r); check("R7 reset bit reads 1", r, 32'h9000);
    wr('h10, 16'h1234);
    wr('h12, 16'hFFFF);
    wr('h00, 16'h0140);
    while (pcs_reset_busy) @(negedge clk);
    rd('h10, r); check("R2 scratch write during reset", r, 32'h1234);
    rd('h12, r); check("R7 write ignored during reset", r, 32'h0);
    rd('h14, r); check("R7 mode cleared", r, 32'h0);
    rd('h00, r); check("R7 ctrl write ignored during reset", r, 32'h1000);
    model_soft_reset();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule